// File: doc/BRIEF.md
# Power-Management Companion Register File

This block is the register file of a power-management companion chip. A serial bus slave elsewhere on the chip decodes each bus frame and turns it into one register access on this block's port. An access is a 5-bit register number plus a flag for read or write, with 16-bit data. Read data is returned combinationally in the same cycle. A write takes effect at the clock edge where the enable is high.

The block holds the following registers:

- a chip identification word;
- a pair of interrupt registers (status and mask) that drive one interrupt line;
- an ADC window, where writing selects a channel and reading returns that channel's result;
- a set of sample-control flags;
- a calibration word;
- two general control words;
- a status word that tracks the power key;
- a watchdog register that can raise a shutdown request.

Hardware event inputs feed the interrupt status register. These are a change of the power key level and the completion of a channel select. The ADC results come from an external bus with one 10-bit slot per channel. The block does not convert anything itself.

Top module: `pmic_regfile`

## Requirements
- R1: Register 0x00 reads 0x0215 when `variant_i` is low and 0x0295 when it is high (bit 7 follows `variant_i`). Writes to 0x00 have no effect.
- R2: Reset values are as follows: interrupt mask 0xFFFF, interrupt status 0x0000, calibration 0x0001, status 0x0020, both control words 0x0000, sample flags 0x0000, channel 0. After reset `irq_o` and `shutdown_o` are low.
- R3: `irq_o` is high exactly when some interrupt status bit is 1 while the mask bit at the same position is 0.
- R4: A write to 0x01 inverts each status bit at a position where the written data holds a 1. A hardware event in the same cycle still leaves its bit set.
- R5: Register 0x02 is the interrupt mask. It takes all 16 written bits and reads them back.
- R6: A read of 0x08 returns the following fields: bits 15..14 are zero, bits 13..10 hold the selected channel, and bits 9..0 hold that channel's result. Channel c's result is slot `adc_results_i[10*c+9 : 10*c]`.
- R7: A write to 0x08 loads the channel from bits 13..10 of the data and sets interrupt status bit 8 (ADC sample done).
- R8: Register 0x09 holds the sample flags. Each 1 on `sample_set_i` sets the flag at that position. A write to 0x09 clears each flag at a position where the data holds a 1. When a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Writing 0x0000 to 0x17 while bit 1 of register 0x0D is 1 raises `shutdown_o`, which then stays high until reset. A nonzero write to 0x17 does not raise it, and neither does any write while that bit is 0. Register 0x17 reads zero.
- R10: Each change of `pwr_key_i` sets interrupt status bit 0 (power key). It also sets status register 0x16 bit 5 to the inverse of the new key level. Register 0x16 ignores writes.
- R11: Calibration (0x06) and the control words (0x0D, 0x0E) are plain 16-bit read/write registers.
- R12: Every other register number reads zero, and writes to it change no register. Interrupt status bits 1 to 7 and 9 to 15 have no hardware source; only R4 writes change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_i | input | 1 | Chip variant select, shown in the identification word |
| acc_en | input | 1 | Register access valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Register number |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data (zero when no read is in progress) |
| pwr_key_i | input | 1 | Power key level |
| sample_set_i | input | 16 | Per-bit set pulses for the sample flags |
| adc_results_i | input | 160 | Result for each of the 16 channels, 10 bits each, channel 0 in the lowest slot |
| irq_o | output | 1 | Interrupt request |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The bench keeps a register model and, after each phase of stimulus, reads all 32 register numbers. This catches decode aliasing and writes that leak into unmapped registers.

The interrupt line is swept one bit at a time, with the mask bit at that position cleared and then set. This separates a correct AND-NOT from an inverted or OR'd mask.

All 16 ADC channels are read under two different result patterns. This separates a wrong slot offset from a wrong field position.

The watchdog is driven with the enable bit both clear and set, and with zero and nonzero data. Collision cases are run in the same cycle: an XOR write with a key event, and a set pulse with a clear write. These expose the wrong priority.

// File: rtl/pmic_regfile.sv
module pmic_regfile #(
  parameter int          ADC_CH       = 16,
  parameter int          ADC_W        = 10,
  parameter logic [15:0] CAL_INIT     = 16'h0001,
  parameter logic [15:0] STAT_INIT    = 16'h0020,
  parameter int          IRQ_PWR_BIT  = 0,
  parameter int          IRQ_ADC_BIT  = 8,
  parameter int          KEY_STAT_BIT = 5,
  parameter int          WDOG_EN_BIT  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     variant_i,
  input  logic                     acc_en,
  input  logic                     acc_wr,
  input  logic [4:0]               acc_addr,
  input  logic [15:0]              acc_wdata,
  output logic [15:0]              acc_rdata,
  input  logic                     pwr_key_i,
  input  logic [15:0]              sample_set_i,
  input  logic [ADC_CH*ADC_W-1:0]  adc_results_i,
  output logic                     irq_o,
  output logic                     shutdown_o
);
  localparam int CH_W  = $clog2(ADC_CH);
  localparam int PAD_W = 16 - CH_W - ADC_W;

  localparam logic [4:0] A_ID   = 5'h00;
  localparam logic [4:0] A_IST  = 5'h01;
  localparam logic [4:0] A_IMSK = 5'h02;
  localparam logic [4:0] A_CAL  = 5'h06;
  localparam logic [4:0] A_ADC  = 5'h08;
  localparam logic [4:0] A_SMP  = 5'h09;
  localparam logic [4:0] A_CC1  = 5'h0D;
  localparam logic [4:0] A_CC2  = 5'h0E;
  localparam logic [4:0] A_STAT = 5'h16;
  localparam logic [4:0] A_WDOG = 5'h17;

  logic [15:0]     ist, imsk, cal, cc1, cc2, smp, stat;
  logic [CH_W-1:0] ch;
  logic            key_q, shut_q;
  logic [15:0]     ist_ev;
  logic [ADC_W-1:0] adc_res;

  wire wr      = acc_en & acc_wr;
  wire rd      = acc_en & ~acc_wr;
  wire wr_ist  = wr && (acc_addr == A_IST);
  wire wr_imsk = wr && (acc_addr == A_IMSK);
  wire wr_cal  = wr && (acc_addr == A_CAL);
  wire wr_adc  = wr && (acc_addr == A_ADC);
  wire wr_smp  = wr && (acc_addr == A_SMP);
  wire wr_cc1  = wr && (acc_addr == A_CC1);
  wire wr_cc2  = wr && (acc_addr == A_CC2);
  wire wr_wdog = wr && (acc_addr == A_WDOG);
  wire key_chg = pwr_key_i ^ key_q;

  always_comb begin
    ist_ev              = '0;
    ist_ev[IRQ_PWR_BIT] = key_chg;
    ist_ev[IRQ_ADC_BIT] = wr_adc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist    <= '0;
      imsk   <= 16'hFFFF;
      cal    <= CAL_INIT;
      cc1    <= '0;
      cc2    <= '0;
      smp    <= '0;
      stat   <= STAT_INIT;
      ch     <= '0;
      key_q  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      ist   <= (wr_ist ? (ist ^ acc_wdata) : ist) | ist_ev;
      smp   <= (wr_smp ? (smp & ~acc_wdata) : smp) | sample_set_i;
      key_q <= pwr_key_i;
      if (wr_imsk) imsk <= acc_wdata;
      if (wr_cal)  cal  <= acc_wdata;
      if (wr_cc1)  cc1  <= acc_wdata;
      if (wr_cc2)  cc2  <= acc_wdata;
      if (wr_adc)  ch   <= acc_wdata[ADC_W +: CH_W];
      if (key_chg) stat[KEY_STAT_BIT] <= ~pwr_key_i;
      if (wr_wdog && acc_wdata == 16'h0000 && cc1[WDOG_EN_BIT]) shut_q <= 1'b1;
    end
  end

  assign adc_res = adc_results_i[ch*ADC_W +: ADC_W];

  always_comb begin
    acc_rdata = '0;
    if (rd) begin
      case (acc_addr)
        A_ID:    acc_rdata = {8'h02, variant_i, 7'h15};
        A_IST:   acc_rdata = ist;
        A_IMSK:  acc_rdata = imsk;
        A_CAL:   acc_rdata = cal;
        A_ADC:   acc_rdata = {{PAD_W{1'b0}}, ch, adc_res};
        A_SMP:   acc_rdata = smp;
        A_CC1:   acc_rdata = cc1;
        A_CC2:   acc_rdata = cc2;
        A_STAT:  acc_rdata = stat;
        default: acc_rdata = '0;
      endcase
    end
  end

  assign irq_o      = |(ist & ~imsk);
  assign shutdown_o = shut_q;

  a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imsk == 16'hFFFF) |-> !irq_o);

  a_r4_xor_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ist && !key_chg) |=> (ist == $past(ist ^ acc_wdata)));

  a_r7_adc_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_adc |=> (ist[IRQ_ADC_BIT] && ch == $past(acc_wdata[ADC_W +: CH_W])));

  a_r8_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_smp && sample_set_i == 16'h0000) |=> (smp == $past(smp & ~acc_wdata)));

  a_r9_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> shutdown_o);

  a_r9_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_o) |-> ($past(wr_wdog) && $past(acc_wdata) == 16'h0000 && $past(cc1[WDOG_EN_BIT])));

  a_r10_key_event: assert property (@(posedge clk) disable iff (!rst_n)
    key_chg |=> (ist[IRQ_PWR_BIT] && stat[KEY_STAT_BIT] == ~$past(pwr_key_i)));
endmodule

// File: tb/pmic_regfile_bench.sv
module pmic_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        variant_i = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        pwr_key_i = 1'b0;
  logic [15:0] sample_set_i = '0;
  logic [159:0] adc_results_i = '0;
  logic        irq_o, shutdown_o;

  int checks = 0, errors = 0, seed = 37;
  bit done = 0;

  logic [15:0] m_st, m_mask, m_cal, m_cc1, m_cc2, m_smp, m_stat;
  logic [3:0]  m_ch;
  logic        m_shut;

  always #2 clk = ~clk;

  pmic_regfile u_pmic_regfile (
    .clk(clk), .rst_n(rst_n), .variant_i(variant_i),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pwr_key_i(pwr_key_i), .sample_set_i(sample_set_i),
    .adc_results_i(adc_results_i), .irq_o(irq_o), .shutdown_o(shutdown_o));

  function automatic logic [9:0] res(input int c);
    res = 10'((c * seed + 5) & 32'h3FF);
  endfunction

  function automatic logic [15:0] exp_rd(input int a);
    case (a)
      5'h00: exp_rd = {8'h02, variant_i, 7'h15};
      5'h01: exp_rd = m_st;
      5'h02: exp_rd = m_mask;
      5'h06: exp_rd = m_cal;
      5'h08: exp_rd = {2'b00, m_ch, res(int'(m_ch))};
      5'h09: exp_rd = m_smp;
      5'h0D: exp_rd = m_cc1;
      5'h0E: exp_rd = m_cc2;
      5'h16: exp_rd = m_stat;
      default: exp_rd = 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic load_results();
    for (int c = 0; c < 16; c++) adc_results_i[c*10 +: 10] = res(c);
  endtask

  task automatic model_wr(input int a, input logic [15:0] d);
    case (a)
      5'h01: m_st = m_st ^ d;
      5'h02: m_mask = d;
      5'h06: m_cal = d;
      5'h08: begin m_ch = d[13:10]; m_st[8] = 1'b1; end
      5'h09: m_smp = m_smp & ~d;
      5'h0D: m_cc1 = d;
      5'h0E: m_cc2 = d;
      5'h17: if (d == 16'h0000 && m_cc1[1]) m_shut = 1'b1;
      default: ;
    endcase
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = 5'(a); acc_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = 5'(a);
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic sweep(input string req);
    logic [15:0] d;
    for (int a = 0; a < 32; a++) begin
      rd(a, d);
      chk(req, d, exp_rd(a));
    end
    chk({req, " irq R3"}, {15'b0, irq_o}, {15'b0, |(m_st & ~m_mask)});
    chk({req, " shutdown R9"}, {15'b0, shutdown_o}, {15'b0, m_shut});
  endtask

  task automatic key(input logic lvl);
    @(negedge clk);
    pwr_key_i = lvl;
    m_st[0] = 1'b1; m_stat[5] = ~lvl;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    m_st = 0; m_mask = 16'hFFFF; m_cal = 16'h0001; m_cc1 = 0; m_cc2 = 0;
    m_smp = 0; m_stat = 16'h0020; m_ch = 0; m_shut = 0;
    load_results();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2: reset values over the whole map
    sweep("R2 reset");

    // R1: identification with both variants, write ignored
    wr(0, 16'hFFFF);
    rd(0, d); chk("R1 id", d, 16'h0215);
    variant_i = 1;
    rd(0, d); chk("R1 id variant", d, 16'h0295);
    variant_i = 0;

    // R5, R11: plain read/write registers
    wr(2, 16'hA5C3); rd(2, d); chk("R5 mask", d, 16'hA5C3);
    wr(6, 16'h1234); rd(6, d); chk("R11 cal", d, 16'h1234);
    wr(13, 16'hBEEF); rd(13, d); chk("R11 cc1", d, 16'hBEEF);
    wr(14, 16'h0F0F); rd(14, d); chk("R11 cc2", d, 16'h0F0F);
    wr(13, 16'h0000);

    // R3, R4: per-bit interrupt sweep
    for (int i = 0; i < 16; i++) begin
      wr(2, ~(16'h1 << i));
      wr(1, 16'h1 << i);
      chk("R3 irq unmasked", {15'b0, irq_o}, 16'h0001);
      rd(1, d); chk("R4 toggle set", d, 16'h1 << i);
      wr(2, 16'hFFFF);
      chk("R3 irq masked", {15'b0, irq_o}, 16'h0000);
      wr(1, 16'h1 << i);
      rd(1, d); chk("R4 toggle clear", d, 16'h0000);
    end
    wr(1, 16'h8421); wr(2, 16'h7BDE);
    sweep("R4 pattern");
    wr(1, 16'h8421);

    // R6, R7: channel select and results, two patterns
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 16; c++) begin
        wr(8, 16'(c << 10) | 16'hC3FF);
        rd(8, d); chk("R6 adc read", d, {2'b00, 4'(c), res(c)});
        rd(1, d); chk("R7 done bit", d & 16'h0100, 16'h0100);
        wr(1, 16'h0100);
      end
      seed = 211; load_results();
    end
    wr(8, 16'h1400);
    chk("R7 irq with mask", {15'b0, irq_o}, 16'h0000);
    wr(2, 16'hFEFF);
    chk("R7 irq unmasked", {15'b0, irq_o}, 16'h0001);
    sweep("R7 sweep");
    wr(1, 16'h0100); wr(2, 16'hFFFF);

    // R8: sample flags
    @(negedge clk); sample_set_i = 16'hF0F3; m_smp |= 16'hF0F3;
    @(negedge clk); sample_set_i = 0;
    rd(9, d); chk("R8 set", d, 16'hF0F3);
    wr(9, 16'h00F1); rd(9, d); chk("R8 clear", d, 16'hF002);
    @(negedge clk);
    sample_set_i = 16'h0002; acc_en = 1; acc_wr = 1; acc_addr = 5'h09; acc_wdata = 16'h0003;
    m_smp = (m_smp & ~16'h0003) | 16'h0002;
    @(negedge clk);
    sample_set_i = 0; acc_en = 0; acc_wr = 0;
    rd(9, d); chk("R8 set wins", d, 16'hF002);

    // R10: power key events
    key(1'b1);
    rd(22, d); chk("R10 key high", d, 16'h0000);
    rd(1, d); chk("R10 irq bit", d & 16'h0001, 16'h0001);
    wr(22, 16'hFFFF); rd(22, d); chk("R10 ro", d, 16'h0000);
    key(1'b0);
    rd(22, d); chk("R10 key low", d, 16'h0020);
    // R4 with a same-cycle key event: bit 0 stays set
    @(negedge clk);
    pwr_key_i = 1; acc_en = 1; acc_wr = 1; acc_addr = 5'h01; acc_wdata = 16'h0003;
    m_st = (m_st ^ 16'h0003) | 16'h0001; m_stat[5] = 0;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
    rd(1, d); chk("R4 event wins", d & 16'h0003, 16'h0003);
    sweep("R10 sweep");

    // R12: unmapped addresses ignore writes
    for (int a = 0; a < 32; a++)
      if (!(a inside {1, 2, 6, 8, 9, 13, 14, 23})) wr(a, 16'hFFFF);
    sweep("R12 unmapped");

    // R9: watchdog
    wr(23, 16'h0000);
    chk("R9 disabled", {15'b0, shutdown_o}, 16'h0000);
    wr(13, 16'h0002);
    wr(23, 16'h0005);
    chk("R9 nonzero", {15'b0, shutdown_o}, 16'h0000);
    rd(23, d); chk("R9 reads zero", d, 16'h0000);
    wr(23, 16'h0000);
    chk("R9 shutdown", {15'b0, shutdown_o}, 16'h0001);
    wr(13, 16'h0000); wr(23, 16'h1111);
    chk("R9 sticky", {15'b0, shutdown_o}, 16'h0001);
    sweep("R9 sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule